// File: doc/BRIEF.md
# Charge Current Combiner and Splitter

This block turns one fast-charge current request into two targets: one for the main charger and one for a parallel helper charger. It first settles on an effective current. Two candidates are formed from the requested total: the total less a temperature-compensation reduction, and the total plus a signed step-charging delta. Each candidate is floored at zero, and the smaller of the two is taken.

The effective current is divided by a master percentage. The part left over goes to the helper after it is scaled by a taper percentage. Any current that the effective value removed from the total is then returned to the master share, so the main charger carries the whole compensation.

One request enters through a valid/ready handshake. The results appear on registered outputs one clock after the request is accepted, and they are held until the consumer takes them. All currents are signed microamp values.

Top module: `chg_current_split`

## Requirements
- R1: While reset is asserted and after reset is released, `out_valid` is 0 and `in_ready` is 1 until a request is accepted.
- R2: The effective current `eff_ua` equals the lower of max(0, total − reduction) and max(0, total + delta), where delta is the conditioned step value.
- R3: When `step_en` is 0, the step delta is taken as 0, whatever value `step_delta_ua` carries.
- R4: When `step_en` is 1, the step delta is limited to the range −3,100,000 to +3,200,000 µA before use.
- R5: `master_pct` is a signed 8-bit value. It is limited to the range 0 to 100 before use.
- R6: `taper_pct` is a signed 8-bit value. It is limited to the range 0 to 100 before use.
- R7: With base = eff × master_pct / 100, truncated, `master_ua` equals max(0, base + total − eff).
- R8: `slave_ua` equals (eff − base) × taper_pct / 100, truncated.
- R9: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its results and `out_valid` = 1 appear after that same edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all result outputs hold their values.
- R11: Any result greater than 2,147,483,647 is output as 2,147,483,647.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can accept a request |
| total_ua | input | 32 | Requested total current, signed µA |
| reduction_ua | input | 32 | Temperature-compensation reduction, signed µA |
| step_en | input | 1 | Step-charging delta is in use |
| step_delta_ua | input | 32 | Step-charging delta, signed µA |
| master_pct | input | 8 | Master share, signed percent |
| taper_pct | input | 8 | Helper taper, signed percent |
| out_valid | output | 1 | Results are present |
| out_ready | input | 1 | The consumer takes the results |
| eff_ua | output | 32 | Effective current, µA |
| master_ua | output | 32 | Master target, µA |
| slave_ua | output | 32 | Helper target, µA |

## Verification
Every result is due on the first rising edge after acceptance. The effective, master and helper currents and `out_valid` all change together at that edge, because there is one register stage.

The bench drives a request on a falling edge and waits for the next rising edge. It samples one time unit after that edge and compares against arithmetic in 64-bit integers.

For back-pressure, the outputs are sampled over several stalled edges and must stay unchanged. The following request is checked one edge after `out_ready` returns.

// File: rtl/chg_split_pkg.sv
package chg_split_pkg;
  // Full scale of every percentage input.
  localparam int PCT_FULL = 100;
  // Default limits applied to the step-charging delta, in microamps.
  localparam int STEP_DELTA_MIN_UA = -3100000;
  localparam int STEP_DELTA_MAX_UA = 3200000;
endpackage

// File: rtl/chg_pct_clamp.sv
module chg_pct_clamp #(
  parameter int PCT_W = 8
) (
  input  logic signed [PCT_W-1:0] raw_pct,
  output logic signed [PCT_W-1:0] lim_pct
);
  import chg_split_pkg::*;

  localparam logic signed [PCT_W-1:0] FULL = PCT_W'(PCT_FULL);

  always_comb begin
    if (raw_pct < 0)         lim_pct = '0;
    else if (raw_pct > FULL) lim_pct = FULL;
    else                     lim_pct = raw_pct;
  end
endmodule

// File: rtl/chg_eff_sel.sv
module chg_eff_sel #(
  parameter int CUR_W     = 32,
  parameter int EXT_W     = CUR_W + 2,
  parameter int DELTA_MIN = chg_split_pkg::STEP_DELTA_MIN_UA,
  parameter int DELTA_MAX = chg_split_pkg::STEP_DELTA_MAX_UA
) (
  input  logic signed [EXT_W-1:0] total_ext,
  input  logic signed [CUR_W-1:0] reduction,
  input  logic                    step_en,
  input  logic signed [CUR_W-1:0] step_delta,
  output logic signed [EXT_W-1:0] eff_ext
);
  localparam int PAD = EXT_W - CUR_W;
  localparam logic signed [CUR_W-1:0] DMIN = CUR_W'(DELTA_MIN);
  localparam logic signed [CUR_W-1:0] DMAX = CUR_W'(DELTA_MAX);

  logic signed [CUR_W-1:0] delta_lim;
  logic signed [EXT_W-1:0] red_ext, delta_ext, cand_cut, cand_step;

  // Delta conditioning: unused when disabled, otherwise limited.
  always_comb begin
    if (!step_en)               delta_lim = '0;
    else if (step_delta < DMIN) delta_lim = DMIN;
    else if (step_delta > DMAX) delta_lim = DMAX;
    else                        delta_lim = step_delta;
  end

  assign red_ext   = {{PAD{reduction[CUR_W-1]}}, reduction};
  assign delta_ext = {{PAD{delta_lim[CUR_W-1]}}, delta_lim};

  // Two candidates, each floored at zero, then the lower one wins.
  always_comb begin
    cand_cut  = total_ext - red_ext;
    cand_step = total_ext + delta_ext;
    if (cand_cut < 0)  cand_cut  = '0;
    if (cand_step < 0) cand_step = '0;
    eff_ext = (cand_cut < cand_step) ? cand_cut : cand_step;
  end
endmodule

// File: rtl/chg_share_calc.sv
module chg_share_calc #(
  parameter int EXT_W = 34,
  parameter int PCT_W = 8
) (
  input  logic signed [EXT_W-1:0] eff_ext,
  input  logic signed [EXT_W-1:0] total_ext,
  input  logic signed [PCT_W-1:0] mst_pct,
  input  logic signed [PCT_W-1:0] tpr_pct,
  output logic signed [EXT_W-1:0] master_ext,
  output logic signed [EXT_W-1:0] slave_ext
);
  import chg_split_pkg::*;

  localparam int PROD_W = EXT_W + PCT_W;
  localparam int PPAD   = PROD_W - PCT_W;
  localparam int EPAD   = PROD_W - EXT_W;
  localparam logic signed [PROD_W-1:0] DIV = PROD_W'(PCT_FULL);

  logic signed [PROD_W-1:0] eff_w, mpct_w, tpct_w, base_w, rest_w, slv_w;
  logic signed [EXT_W-1:0]  base, rest, msum;

  assign eff_w  = {{EPAD{eff_ext[EXT_W-1]}}, eff_ext};
  assign mpct_w = {{PPAD{mst_pct[PCT_W-1]}}, mst_pct};
  assign tpct_w = {{PPAD{tpr_pct[PCT_W-1]}}, tpr_pct};

  // Master base share, truncating division by full scale.
  assign base_w = (eff_w * mpct_w) / DIV;
  assign base   = base_w[EXT_W-1:0];

  // Helper share from what the master base leaves over.
  assign rest   = eff_ext - base;
  assign rest_w = {{EPAD{rest[EXT_W-1]}}, rest};
  assign slv_w  = (rest_w * tpct_w) / DIV;
  assign slave_ext = slv_w[EXT_W-1:0];

  // Compensation removed from the total returns to the master.
  always_comb begin
    msum = base + total_ext - eff_ext;
    master_ext = (msum < 0) ? '0 : msum;
  end
endmodule

// File: rtl/chg_current_split.sv
module chg_current_split #(
  parameter int CUR_W     = 32,
  parameter int PCT_W     = 8,
  parameter int DELTA_MIN = chg_split_pkg::STEP_DELTA_MIN_UA,
  parameter int DELTA_MAX = chg_split_pkg::STEP_DELTA_MAX_UA
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [CUR_W-1:0] total_ua,
  input  logic signed [CUR_W-1:0] reduction_ua,
  input  logic                    step_en,
  input  logic signed [CUR_W-1:0] step_delta_ua,
  input  logic signed [PCT_W-1:0] master_pct,
  input  logic signed [PCT_W-1:0] taper_pct,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [CUR_W-1:0] eff_ua,
  output logic signed [CUR_W-1:0] master_ua,
  output logic signed [CUR_W-1:0] slave_ua
);
  localparam int EXT_W = CUR_W + 2;
  localparam int PAD   = EXT_W - CUR_W;
  localparam int NPCT  = 2;
  localparam logic signed [EXT_W-1:0] CUR_MAX =
    {{(PAD+1){1'b0}}, {(CUR_W-1){1'b1}}};

  logic signed [EXT_W-1:0] total_ext, eff_ext, master_ext, slave_ext;
  logic signed [PCT_W-1:0] pct_raw [NPCT];
  logic signed [PCT_W-1:0] pct_lim [NPCT];
  logic signed [CUR_W-1:0] res_d [3];
  logic signed [EXT_W-1:0] res_x [3];
  logic signed [CUR_W-1:0] eff_q, master_q, slave_q;
  logic signed [CUR_W-1:0] eff_d, master_d, slave_d;
  logic                    vld_q, vld_d, accept, res_en;

  assign total_ext  = {{PAD{total_ua[CUR_W-1]}}, total_ua};
  assign pct_raw[0] = master_pct;
  assign pct_raw[1] = taper_pct;

  for (genvar g = 0; g < NPCT; g++) begin : g_pct
    chg_pct_clamp #(.PCT_W(PCT_W)) u_clamp (
      .raw_pct (pct_raw[g]),
      .lim_pct (pct_lim[g])
    );
  end

  chg_eff_sel #(
    .CUR_W(CUR_W), .EXT_W(EXT_W),
    .DELTA_MIN(DELTA_MIN), .DELTA_MAX(DELTA_MAX)
  ) u_eff (
    .total_ext  (total_ext),
    .reduction  (reduction_ua),
    .step_en    (step_en),
    .step_delta (step_delta_ua),
    .eff_ext    (eff_ext)
  );

  chg_share_calc #(.EXT_W(EXT_W), .PCT_W(PCT_W)) u_share (
    .eff_ext    (eff_ext),
    .total_ext  (total_ext),
    .mst_pct    (pct_lim[0]),
    .tpr_pct    (pct_lim[1]),
    .master_ext (master_ext),
    .slave_ext  (slave_ext)
  );

  // Saturate every non-negative result to the output width.
  assign res_x[0] = eff_ext;
  assign res_x[1] = master_ext;
  assign res_x[2] = slave_ext;
  for (genvar r = 0; r < 3; r++) begin : g_sat
    assign res_d[r] = (res_x[r] > CUR_MAX) ? CUR_MAX[CUR_W-1:0]
                                           : res_x[r][CUR_W-1:0];
  end

  // Handshake and next state.
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign res_en   = accept;

  always_comb begin
    vld_d = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    eff_d    = res_d[0];
    master_d = res_d[1];
    slave_d  = res_d[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q    <= '0;
      master_q <= '0;
      slave_q  <= '0;
    end else if (res_en) begin
      eff_q    <= eff_d;
      master_q <= master_d;
      slave_q  <= slave_d;
    end
  end

  assign out_valid = vld_q;
  assign eff_ua    = eff_q;
  assign master_ua = master_q;
  assign slave_ua  = slave_q;
endmodule

// File: rtl/chg_current_split_chk.sv
module chg_current_split_chk #(
  parameter int CUR_W = 32,
  parameter int PCT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [CUR_W-1:0] eff_ua,
  input logic signed [CUR_W-1:0] master_ua,
  input logic signed [CUR_W-1:0] slave_ua
);
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(eff_ua)
      && $stable(master_ua) && $stable(slave_ua));

  assert_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (master_ua >= 0) && (eff_ua >= 0));

  assert_slave_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (slave_ua >= 0) && (slave_ua <= eff_ua));

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind chg_current_split chg_current_split_chk #(.CUR_W(CUR_W), .PCT_W(PCT_W)) u_chk (.*);

// File: tb/chg_current_split_bench.sv
`timescale 1ns/1ps
module chg_current_split_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, step_en, out_valid, out_ready;
  logic signed [31:0] total_ua, reduction_ua, step_delta_ua;
  logic signed [7:0]  master_pct, taper_pct;
  logic signed [31:0] eff_ua, master_ua, slave_ua;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  chg_current_split u_chg_current_split (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .total_ua(total_ua), .reduction_ua(reduction_ua), .step_en(step_en),
    .step_delta_ua(step_delta_ua), .master_pct(master_pct),
    .taper_pct(taper_pct), .out_valid(out_valid), .out_ready(out_ready),
    .eff_ua(eff_ua), .master_ua(master_ua), .slave_ua(slave_ua)
  );

  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction
  function automatic longint lmin(longint a, longint b);
    return (a < b) ? a : b;
  endfunction
  function automatic longint sat(longint v);
    return (v > 64'sd2147483647) ? 64'sd2147483647 : v;
  endfunction

  longint x_eff, x_mst, x_slv;

  task automatic model(longint t, longint r, bit en, longint d,
                       longint mp, longint tp);
    longint dd, base, e;
    dd = en ? lmin(lmax(d, -3100000), 3200000) : 0;      // R3 R4
    mp = lmin(lmax(mp, 0), 100);                          // R5
    tp = lmin(lmax(tp, 0), 100);                          // R6
    e  = lmin(lmax(0, t - r), lmax(0, t + dd));           // R2
    base  = (e * mp) / 100;
    x_eff = sat(e);                                       // R11
    x_mst = sat(lmax(0, base + t - e));                   // R7
    x_slv = sat(((e - base) * tp) / 100);                 // R8
  endtask

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one request, accept it at the next edge, check one unit later.
  task automatic run_vec(string tag, longint t, longint r, bit en,
                         longint d, longint mp, longint tp);
    @(negedge clk);
    total_ua = 32'(t); reduction_ua = 32'(r); step_en = en;
    step_delta_ua = 32'(d); master_pct = 8'(mp); taper_pct = 8'(tp);
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    model(t, r, en, d, mp, tp);
    check({tag, " R9 out_valid"}, longint'(out_valid), 1);
    check({tag, " R2 eff"}, eff_ua, x_eff);
    check({tag, " R7 master"}, master_ua, x_mst);
    check({tag, " R8 slave"}, slave_ua, x_slv);
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint tots[5]  = '{0, 1500000, 3000000, -200000, 2147483647};
    longint reds[3]  = '{0, 500000, -10};
    longint dels[6]  = '{-4000000, -3100000, 0, 3200000, 5000000, -500000};
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; step_en = 1'b0;
    total_ua = '0; reduction_ua = '0; step_delta_ua = '0;
    master_pct = '0; taper_pct = '0;
    repeat (3) @(posedge clk); #1;
    check("R1 reset out_valid", longint'(out_valid), 0);
    check("R1 reset in_ready", longint'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle out_valid", longint'(out_valid), 0);
    check("R1 idle in_ready", longint'(in_ready), 1);

    // Directed corner cases.
    run_vec("R3 step off", 5000000, 0, 1'b0, -4000000, 60, 50);
    check("R3 eff ignores delta", eff_ua, 5000000);
    run_vec("R4 low limit", 5000000, 0, 1'b1, -4000000, 60, 50);
    check("R4 eff clamped", eff_ua, 1900000);
    run_vec("R4 high limit", 1000000, -9000000, 1'b1, 9000000, 100, 0);
    check("R4 eff high clamp", eff_ua, 4200000);
    run_vec("R11 sat", 2147483647, -10, 1'b1, 3200000, 0, 100);
    check("R11 slave saturated", slave_ua, 2147483647);
    run_vec("R7 floor", -200000, 0, 1'b1, 0, 50, 50);
    check("R7 master floored", master_ua, 0);

    // Sweep of currents with fixed shares.
    foreach (tots[i]) foreach (reds[j]) foreach (dels[k])
      for (int en = 0; en < 2; en++)
        run_vec("R2 sweep", tots[i], reds[j], en[0], dels[k], 60, 75);

    // Sweep of percentages past both limits.
    for (int p = -8; p <= 110; p++) begin
      run_vec("R5 R6 pct", 2345678, 300000, 1'b1, -100000, p, 110 - p);
      run_vec("R5 R6 pct neg", 987654, 0, 1'b0, 0, -p, p);
    end

    // Back-pressure: results hold while the consumer stalls.
    @(negedge clk);
    total_ua = 2000000; reduction_ua = 0; step_en = 1'b0;
    step_delta_ua = 0; master_pct = 40; taper_pct = 100;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    check("R9 stall accept", longint'(out_valid), 1);
    check("R9 stall master", master_ua, 800000);
    @(negedge clk);
    total_ua = 1000000; master_pct = 100;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check("R10 in_ready low", longint'(in_ready), 0);
      check("R10 master held", master_ua, 800000);
      check("R10 slave held", slave_ua, 1200000);
    end
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    check("R10 next accepted", master_ua, 1000000);
    check("R10 next slave", slave_ua, 0);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R9 drained", longint'(out_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule